// File: doc/BRIEF.md
# Layer Pixel Format Unpacker

This block takes one packed pixel word of a display layer, together with a 3-bit format code, and expands it into a 32-bit ARGB word with 8 bits per channel, ready for the blending stage. Direct colour formats are unpacked field by field, and narrow channels are widened to 8 bits. Luminance-indexed formats use their index either to look up a 24-bit RGB colour in an internal 256-entry table or, when the table is switched off, to produce a grey level.

A separate write port loads the colour table one entry per cycle. Whether the output alpha comes from the pixel or is forced to fully opaque depends only on the format code. The result is registered, so each valid input appears on the output one clock later with its own valid flag.

Top module: `pix_unpack`

## Requirements
- R1: Format code 0 (32-bit ARGB) passes the word unchanged: alpha is [31:24], red [23:16], green [15:8] and blue [7:0].
- R2: Format code 1 (24-bit RGB) takes red [23:16], green [15:8] and blue [7:0], and forces the output alpha to 0xFF.
- R3: Format code 2 (16-bit 5-6-5) takes red [15:11], green [10:5] and blue [4:0], and forces alpha to 0xFF. A 5-bit field x widens to {x, x[4:2]} and a 6-bit field widens to {x, x[5:4]}.
- R4: Format code 3 (16-bit 1-5-5-5) takes alpha bit [15], red [14:10], green [9:5] and blue [4:0]. The alpha bit becomes 0x00 or 0xFF, and each colour field widens as in R3.
- R5: Format code 4 (16-bit 4-4-4-4) takes alpha [15:12], red [11:8], green [7:4] and blue [3:0]. Each 4-bit field x widens to {x, x}.
- R6: Format code 5 (8-bit luminance) uses [7:0] as the table index and forces alpha to 0xFF. With the table enabled, RGB is the table entry at that index, with red at [23:16] of the entry.
- R7: Format code 6 (4-bit alpha, 4-bit luminance) takes alpha [7:4], widened to {a, a}, and the index [3:0]. With the table enabled, the index is zero-extended to 8 bits to address the table.
- R8: Format code 7 (8-bit alpha, 8-bit luminance) takes alpha [15:8] and the index [7:0].
- R9: With the table enable low, an indexed format drives its luminance to all three colour channels. An 8-bit index is used as is; a 4-bit index is widened to {i, i}. Alpha follows R6 to R8.
- R10: A table write (write enable high, 8-bit address, 24-bit RGB) is visible to pixels presented in any later cycle. Table contents have no effect on the direct formats 0 to 4.
- R11: The output valid is the input valid delayed by one clock. The output word for a pixel appears in the cycle after it is presented.
- R12: While the input valid is low, the output word holds its last value. Reset clears the output valid and the output word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_data_i | input | 32 | Packed pixel word |
| in_fmt_i | input | 3 | Format code 0..7 |
| lut_en_i | input | 1 | Colour table enable for indexed formats |
| lut_we_i | input | 1 | Colour table write enable |
| lut_addr_i | input | 8 | Colour table write address |
| lut_rgb_i | input | 24 | Colour table write data, red in [23:16] |
| out_valid_o | output | 1 | Output pixel valid |
| out_argb_o | output | 32 | Unpacked ARGB, 8 bits per channel |

## Verification
The bench builds the block with its default parameters: 8-bit channels and an 8-bit table address. This gives all 256 table entries and all eight format codes. It first fills every table entry with a distinct pattern, so every index used by random pixels returns a known colour. Because 4-bit indices only reach the lowest sixteen entries, the upper entries are distinguishable, and a wrong extension of the 4-bit index shows up. Table entries are rewritten during the random stream, between pixels, to exercise how writes order against reads.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  typedef enum logic [2:0] {
    FMT_ARGB32 = 3'd0,
    FMT_RGB24  = 3'd1,
    FMT_RGB565 = 3'd2,
    FMT_A1RGB5 = 3'd3,
    FMT_ARGB4  = 3'd4,
    FMT_LUM8   = 3'd5,
    FMT_A4LUM4 = 3'd6,
    FMT_A8LUM8 = 3'd7
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] alpha;
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
    logic       indexed;
    logic [7:0] lum_idx;
    logic [7:0] grey;
  } pix_fields_t;

  function automatic logic [7:0] widen4(input logic [3:0] x);
    return {x, x};
  endfunction

  function automatic logic [7:0] widen5(input logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] x);
    return {x, x[5:4]};
  endfunction

endpackage

// File: rtl/pix_lut.sv
module pix_lut #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Read is combinational, so the table adds no cycle to the pixel path.
  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pix_decode.sv
module pix_decode
  import pix_unpack_pkg::*;
(
  input  logic [31:0] data_i,
  input  logic [2:0]  fmt_i,
  output pix_fields_t fld_o
);
  pix_fmt_e fmt;
  assign fmt = pix_fmt_e'(fmt_i);

  always_comb begin
    fld_o = '0;
    unique case (fmt)
      FMT_ARGB32: begin
        fld_o.alpha = data_i[31:24];
        fld_o.red   = data_i[23:16];
        fld_o.green = data_i[15:8];
        fld_o.blue  = data_i[7:0];
      end
      FMT_RGB24: begin
        fld_o.alpha = 8'hFF;
        fld_o.red   = data_i[23:16];
        fld_o.green = data_i[15:8];
        fld_o.blue  = data_i[7:0];
      end
      FMT_RGB565: begin
        fld_o.alpha = 8'hFF;
        fld_o.red   = widen5(data_i[15:11]);
        fld_o.green = widen6(data_i[10:5]);
        fld_o.blue  = widen5(data_i[4:0]);
      end
      FMT_A1RGB5: begin
        fld_o.alpha = {8{data_i[15]}};
        fld_o.red   = widen5(data_i[14:10]);
        fld_o.green = widen5(data_i[9:5]);
        fld_o.blue  = widen5(data_i[4:0]);
      end
      FMT_ARGB4: begin
        fld_o.alpha = widen4(data_i[15:12]);
        fld_o.red   = widen4(data_i[11:8]);
        fld_o.green = widen4(data_i[7:4]);
        fld_o.blue  = widen4(data_i[3:0]);
      end
      FMT_LUM8: begin
        fld_o.alpha   = 8'hFF;
        fld_o.indexed = 1'b1;
        fld_o.lum_idx = data_i[7:0];
        fld_o.grey    = data_i[7:0];
      end
      FMT_A4LUM4: begin
        fld_o.alpha   = widen4(data_i[7:4]);
        fld_o.indexed = 1'b1;
        fld_o.lum_idx = {4'd0, data_i[3:0]};
        fld_o.grey    = widen4(data_i[3:0]);
      end
      FMT_A8LUM8: begin
        fld_o.alpha   = data_i[15:8];
        fld_o.indexed = 1'b1;
        fld_o.lum_idx = data_i[7:0];
        fld_o.grey    = data_i[7:0];
      end
      default: fld_o = '0;
    endcase
  end

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
  import pix_unpack_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int LUT_AW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  input  logic [31:0]         in_data_i,
  input  logic [2:0]          in_fmt_i,
  input  logic                lut_en_i,
  input  logic                lut_we_i,
  input  logic [LUT_AW-1:0]   lut_addr_i,
  input  logic [3*CH_W-1:0]   lut_rgb_i,
  output logic                out_valid_o,
  output logic [4*CH_W-1:0]   out_argb_o
);
  localparam int RGB_W = 3 * CH_W;

  pix_fields_t          fld;
  logic [RGB_W-1:0]     lut_rd;
  logic [RGB_W-1:0]     rgb_sel;

  pix_decode u_dec (
    .data_i (in_data_i),
    .fmt_i  (in_fmt_i),
    .fld_o  (fld)
  );

  pix_lut #(.AW(LUT_AW), .DW(RGB_W)) u_lut (
    .clk_i   (clk_i),
    .we_i    (lut_we_i),
    .waddr_i (lut_addr_i),
    .wdata_i (lut_rgb_i),
    .raddr_i (fld.lum_idx[LUT_AW-1:0]),
    .rdata_o (lut_rd)
  );

  always_comb begin
    if (!fld.indexed)  rgb_sel = {fld.red, fld.green, fld.blue};
    else if (lut_en_i) rgb_sel = lut_rd;
    else               rgb_sel = {fld.grey, fld.grey, fld.grey};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_argb_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_argb_o <= {fld.alpha, rgb_sel};
    end
  end

  a_r11_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r11_idle_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_argb_o));
  a_r2_opaque: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (in_fmt_i == 3'd1 || in_fmt_i == 3'd2 || in_fmt_i == 3'd5))
    |=> out_argb_o[31:24] == 8'hFF);
  a_r4_alpha_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_fmt_i == 3'd3)
    |=> (out_argb_o[31:24] == 8'h00 || out_argb_o[31:24] == 8'hFF));
  a_r7_alpha_dup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_fmt_i == 3'd6) |=> out_argb_o[31:28] == out_argb_o[27:24]);
  a_r1_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_fmt_i == 3'd0) |=> out_argb_o == $past(in_data_i));

endmodule

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_fmt = '0;
  logic        lut_en = 1'b0;
  logic        lut_we = 1'b0;
  logic [7:0]  lut_addr = '0;
  logic [23:0] lut_rgb = '0;
  logic        out_valid;
  logic [31:0] out_argb;

  int checks = 0;
  int errors = 0;
  logic [23:0] lut_m [256];

  always #(CLK_NS/2) clk = ~clk;

  pix_unpack u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_fmt_i(in_fmt), .lut_en_i(lut_en), .lut_we_i(lut_we), .lut_addr_i(lut_addr),
    .lut_rgb_i(lut_rgb), .out_valid_o(out_valid), .out_argb_o(out_argb)
  );

  function automatic logic [7:0] w4(input logic [3:0] x); return {x, x}; endfunction
  function automatic logic [7:0] w5(input logic [4:0] x); return {x, x[4:2]}; endfunction
  function automatic logic [7:0] w6(input logic [5:0] x); return {x, x[5:4]}; endfunction

  function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] d, input logic en);
    logic [7:0] a, idx, g;
    case (f)
      3'd0: return d;
      3'd1: return {8'hFF, d[23:0]};
      3'd2: return {8'hFF, w5(d[15:11]), w6(d[10:5]), w5(d[4:0])};
      3'd3: return {d[15] ? 8'hFF : 8'h00, w5(d[14:10]), w5(d[9:5]), w5(d[4:0])};
      3'd4: return {w4(d[15:12]), w4(d[11:8]), w4(d[7:4]), w4(d[3:0])};
      default: begin
        if (f == 3'd5)      begin a = 8'hFF;       idx = d[7:0];         g = d[7:0]; end
        else if (f == 3'd6) begin a = w4(d[7:4]);  idx = {4'd0, d[3:0]}; g = w4(d[3:0]); end
        else                begin a = d[15:8];     idx = d[7:0];         g = d[7:0]; end
        return en ? {a, lut_m[idx]} : {a, g, g, g};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] f, input logic en);
    if (f >= 3'd5 && !en) return "R9";
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic vexp, input logic [31:0] exp);
    checks++;
    if (out_valid !== vexp || out_argb !== exp) begin
      errors++;
      $display("FAIL %s: valid=%0b argb=%08h expected valid=%0b argb=%08h",
               tag, out_valid, out_argb, vexp, exp);
    end
  endtask

  task automatic lut_write(input logic [7:0] a, input logic [23:0] v);
    @(negedge clk);
    in_valid = 1'b0; lut_we = 1'b1; lut_addr = a; lut_rgb = v;
    @(posedge clk); #1;
    lut_we = 1'b0;
    lut_m[a] = v;
  endtask

  // Present one pixel and check it in the following cycle.
  task automatic pixel(input logic [2:0] f, input logic [31:0] d, input logic en, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_data = d; lut_en = en;
    @(posedge clk); #1;
    check(tag, 1'b1, model(f, d, en));
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last;
    void'($urandom(32'd4242));
    #(CLK_NS * 3);
    #1 check("R12", 1'b0, 32'h0);  // reset state
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 256; i++)
      lut_write(i[7:0], {i[7:0] ^ 8'h5A, i[7:0] * 8'd3, ~i[7:0]});
    check("R12", 1'b0, 32'h0);

    pixel(3'd0, 32'h12345678, 1'b0, "R1");
    pixel(3'd1, 32'h00ABCDEF, 1'b1, "R2");
    pixel(3'd2, 32'h0000F81F, 1'b0, "R3");
    pixel(3'd2, 32'h000007E0, 1'b0, "R3");
    pixel(3'd3, 32'h0000FFFF, 1'b0, "R4");
    pixel(3'd3, 32'h00007C00, 1'b0, "R4");
    pixel(3'd4, 32'h0000A5C3, 1'b1, "R5");
    pixel(3'd5, 32'h000000C8, 1'b1, "R6");
    pixel(3'd6, 32'h000000F7, 1'b1, "R7");
    pixel(3'd6, 32'hFFFFFF3C, 1'b1, "R7");
    pixel(3'd7, 32'h00007FC8, 1'b1, "R8");
    pixel(3'd5, 32'h00000091, 1'b0, "R9");
    pixel(3'd6, 32'h0000002B, 1'b0, "R9");
    pixel(3'd7, 32'h000040FE, 1'b0, "R9");

    lut_write(8'hC8, 24'h13579B);
    pixel(3'd5, 32'h000000C8, 1'b1, "R10");
    pixel(3'd0, 32'hCAFEF00D, 1'b1, "R10");
    pixel(3'd2, 32'h0000ABCD, 1'b1, "R11");

    last = out_argb;
    @(negedge clk); in_valid = 1'b0; in_data = 32'hFFFFFFFF; in_fmt = 3'd0;
    @(posedge clk); #1 check("R12", 1'b0, last);
    @(posedge clk); #1 check("R11", 1'b0, last);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  f = 3'($urandom);
      logic [31:0] d = $urandom;
      logic        en = ($urandom % 4) != 0;
      if (n % 64 == 63) lut_write(8'($urandom), 24'($urandom));
      pixel(f, d, en, tag_of(f, en));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule